// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Unit

This block holds the machine-mode control and status registers of a single-issue 32-bit core and decides when the core must leave its normal instruction stream. The pipeline presents one CSR access at a time: a 3-bit operation, a 12-bit address, a register operand, a 5-bit immediate and a flag that says the source register is x0. In the same cycle the unit returns the register's previous contents. On the next clock edge it writes the merged value, unless a write-suppression rule applies.

The unit also receives synchronous exception requests (environment call, breakpoint and illegal instruction, each with the PC and instruction word of the trapping instruction), three interrupt lines (software, timer, external), a signal that a pipeline flush is in progress, and a trap-return request. When a trap or return is accepted, the unit raises `redirect_valid` in that same cycle with the new fetch address on `redirect_pc`. The pipeline uses this as both the flush and the redirect. All state moves on the following clock edge. Decode, pipeline flushing and branch prediction belong to the surrounding core.

Top module: `mtrap_csr_unit`

## Requirements
- R1: Operation 3'b001 (write) and 3'b101 (write immediate) store the source value, and `csr_rdata` returns the previous contents in the same cycle. The scratch register (address 0x340) resets to 0.
- R2: Operations 3'b010 (set) and 3'b011 (clear) OR or AND-NOT the register operand into the CSR and return the old value. For example, 0x42 set with 0xF gives 0x4F, and a following clear with 0xF gives 0x40.
- R3: No write happens for set or clear with `csr_src_x0` high. No write happens for 3'b110 or 3'b111 with a zero immediate. The access is still a read.
- R4: The immediate forms (3'b101, 3'b110, 3'b111) use `csr_zimm` zero-extended to 32 bits and ignore `csr_src`. Writing 0x1F and then clearing bit 4 leaves 0x0F.
- R5: Synchronous causes are written to mcause (0x342): illegal instruction 2, breakpoint 3, environment call 11. When several are requested together, illegal instruction wins over breakpoint, and breakpoint wins over environment call.
- R6: On trap entry, mepc (0x341) takes `trap_pc`. mtval (0x343) takes `trap_insn` for an illegal instruction and 0 for every other trap.
- R7: On trap entry, mstatus (0x300) bit 7 takes the old bit 3, and bit 3 is cleared. The redirect target is mtvec (0x305) with bits 1:0 forced to 0. mtvec resets to `TVEC_RESET`.
- R8: A return request redirects to mepc. It then sets mstatus bit 3 from bit 7 and sets bit 7 to 1.
- R9: An interrupt is taken only when mstatus bit 3 is set and its line and its enable bit in mie (0x304) are both high. The enable bits are 11 external, 3 software and 7 timer. The cause is 0x8000000B, 0x80000003 or 0x80000007, with external over software over timer.
- R10: A synchronous exception is taken even while `flush_busy` is high, and it takes priority over pending interrupts and a return request. An interrupt is held off while `flush_busy` is high.
- R11: Writes to mepc and mtvec clear bits 1:0. Only bits 3 and 7 of mstatus are writable, and bits 12:11 always read as 1. Only bits 3, 7 and 11 of mie are writable. mip (0x344) reads the live interrupt lines at bits 3, 7 and 11 and ignores writes.
- R12: An access to an unimplemented address, or with operation 3'b000 or 3'b100, raises `csr_illegal` in the same cycle and writes nothing.
- R13: A CSR access presented in a cycle that takes a trap or a return performs no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | A CSR access is presented this cycle |
| csr_op | input | 3 | Access operation (bit 2 selects the immediate; bits 1:0 are 01 write, 10 set, 11 clear) |
| csr_addr | input | 12 | CSR address |
| csr_src | input | 32 | Register operand |
| csr_zimm | input | 5 | Immediate operand |
| csr_src_x0 | input | 1 | The source register is x0 |
| csr_rdata | output | 32 | Previous contents of the addressed CSR |
| csr_illegal | output | 1 | The access is illegal |
| exc_ecall | input | 1 | Environment call request |
| exc_ebreak | input | 1 | Breakpoint request |
| exc_illegal | input | 1 | Illegal instruction request |
| trap_pc | input | 32 | PC of the trapping or interrupted instruction |
| trap_insn | input | 32 | Instruction word of the trapping instruction |
| irq_sw | input | 1 | Software interrupt line |
| irq_timer | input | 1 | Timer interrupt line |
| irq_ext | input | 1 | External interrupt line |
| flush_busy | input | 1 | A pipeline flush is in progress |
| mret_req | input | 1 | Trap-return request |
| redirect_valid | output | 1 | Flush and redirect fetch this cycle |
| redirect_pc | output | 32 | Redirect target |

## Verification
The in-line assertions check on every cycle that:
- trap entry clears the global enable and saves it in bit 7;
- a return restores the enable and sets bit 7;
- an interrupt is never taken while masked, during a flush, or alongside an exception;
- an exception records its cause with bit 31 clear;
- an illegal access never writes;
- a read-only form of access leaves the scratch register unchanged;
- redirect targets are word aligned.

Only the bench scenarios can show the remaining behaviour: the exact cause values and their ordering, the exact values returned by the chained read-modify-write sequence, the field masking of each register, and the deferred interrupt being taken once the flush ends.

// File: rtl/mtrap_csr_unit.sv
module mtrap_csr_unit #(
  parameter logic [31:0] TVEC_RESET = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_req,
  input  logic [2:0]  csr_op,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_src,
  input  logic [4:0]  csr_zimm,
  input  logic        csr_src_x0,
  output logic [31:0] csr_rdata,
  output logic        csr_illegal,
  input  logic        exc_ecall,
  input  logic        exc_ebreak,
  input  logic        exc_illegal,
  input  logic [31:0] trap_pc,
  input  logic [31:0] trap_insn,
  input  logic        irq_sw,
  input  logic        irq_timer,
  input  logic        irq_ext,
  input  logic        flush_busy,
  input  logic        mret_req,
  output logic        redirect_valid,
  output logic [31:0] redirect_pc
);
  localparam logic [11:0] A_STATUS  = 12'h300;
  localparam logic [11:0] A_IE      = 12'h304;
  localparam logic [11:0] A_TVEC    = 12'h305;
  localparam logic [11:0] A_SCRATCH = 12'h340;
  localparam logic [11:0] A_EPC     = 12'h341;
  localparam logic [11:0] A_CAUSE   = 12'h342;
  localparam logic [11:0] A_TVAL    = 12'h343;
  localparam logic [11:0] A_IP      = 12'h344;

  logic        st_mie, st_mpie;
  logic [2:0]  ie_q;
  logic [31:0] tvec_q, scratch_q, epc_q, cause_q, tval_q;

  logic [31:0] status_v, ie_v, ip_v, old_v, src_v, wdata;
  logic        hit, op_imm, wr_want, csr_we;
  logic [1:0]  kind;
  logic        exc_any, irq_take, mret_take, trap_take;
  logic [2:0]  pend;
  logic [31:0] cause_next;

  assign status_v = 32'h0000_1800 | (32'(st_mpie) << 7) | (32'(st_mie) << 3);
  assign ie_v     = (32'(ie_q[2]) << 11) | (32'(ie_q[1]) << 7) | (32'(ie_q[0]) << 3);
  assign ip_v     = (32'(irq_ext) << 11) | (32'(irq_timer) << 7) | (32'(irq_sw) << 3);

  always_comb begin
    hit   = 1'b1;
    old_v = '0;
    case (csr_addr)
      A_STATUS:  old_v = status_v;
      A_IE:      old_v = ie_v;
      A_TVEC:    old_v = tvec_q;
      A_SCRATCH: old_v = scratch_q;
      A_EPC:     old_v = epc_q;
      A_CAUSE:   old_v = cause_q;
      A_TVAL:    old_v = tval_q;
      A_IP:      old_v = ip_v;
      default:   hit = 1'b0;
    endcase
  end

  assign op_imm = csr_op[2];
  assign kind   = csr_op[1:0];
  assign src_v  = op_imm ? {27'b0, csr_zimm} : csr_src;

  always_comb begin
    case (kind)
      2'b01:   wdata = src_v;
      2'b10:   wdata = old_v | src_v;
      2'b11:   wdata = old_v & ~src_v;
      default: wdata = old_v;
    endcase
  end

  assign wr_want     = (kind == 2'b01) ||
                       ((kind != 2'b00) && (op_imm ? (csr_zimm != 5'd0) : !csr_src_x0));
  assign csr_illegal = csr_req && (!hit || kind == 2'b00);
  assign csr_rdata   = old_v;

  assign exc_any   = exc_ecall | exc_ebreak | exc_illegal;
  assign pend      = {irq_ext & ie_q[2], irq_timer & ie_q[1], irq_sw & ie_q[0]};
  assign irq_take  = st_mie && (|pend) && !flush_busy && !exc_any && !mret_req;
  assign mret_take = mret_req && !exc_any;
  assign trap_take = exc_any || irq_take;
  assign csr_we    = csr_req && !csr_illegal && wr_want && !trap_take && !mret_take;

  always_comb begin
    if (exc_illegal)     cause_next = 32'd2;
    else if (exc_ebreak) cause_next = 32'd3;
    else if (exc_ecall)  cause_next = 32'd11;
    else if (pend[2])    cause_next = 32'h8000_000B;
    else if (pend[0])    cause_next = 32'h8000_0003;
    else                 cause_next = 32'h8000_0007;
  end

  assign redirect_valid = trap_take || mret_take;
  assign redirect_pc    = trap_take ? tvec_q : epc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_mie    <= 1'b0;
      st_mpie   <= 1'b0;
      ie_q      <= '0;
      tvec_q    <= TVEC_RESET & ~32'h3;
      scratch_q <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
      tval_q    <= '0;
    end else if (trap_take) begin
      epc_q   <= trap_pc & ~32'h3;
      cause_q <= cause_next;
      tval_q  <= exc_illegal ? trap_insn : 32'h0;
      st_mpie <= st_mie;
      st_mie  <= 1'b0;
    end else if (mret_take) begin
      st_mie  <= st_mpie;
      st_mpie <= 1'b1;
    end else if (csr_we) begin
      case (csr_addr)
        A_STATUS:  begin st_mie <= wdata[3]; st_mpie <= wdata[7]; end
        A_IE:      ie_q <= {wdata[11], wdata[7], wdata[3]};
        A_TVEC:    tvec_q <= wdata & ~32'h3;
        A_SCRATCH: scratch_q <= wdata;
        A_EPC:     epc_q <= wdata & ~32'h3;
        A_CAUSE:   cause_q <= wdata;
        A_TVAL:    tval_q <= wdata;
        default: ;
      endcase
    end
  end

  assert_trap_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> (!st_mie && st_mpie == $past(st_mie)));

  assert_return_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mret_take |=> (st_mpie && st_mie == $past(st_mpie)));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !exc_any && !mret_req) |-> (st_mie && !flush_busy && (|pend)));

  assert_exc_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_any |=> !cause_q[31]);

  assert_illegal_nowrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal && csr_addr == A_SCRATCH) |=> $stable(scratch_q));

  assert_readonly_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_addr == A_SCRATCH && csr_op[1] &&
     (csr_op[2] ? (csr_zimm == 5'd0) : csr_src_x0)) |=> $stable(scratch_q));

  assert_target_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[1:0] == 2'b00));
endmodule

// File: tb/mtrap_csr_unit_tb.sv
`timescale 1ns/1ps
module mtrap_csr_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req = 0, x0 = 0, ecall = 0, ebreak = 0, illeg = 0;
  logic        isw = 0, itm = 0, iex = 0, fbusy = 0, mret = 0;
  logic [2:0]  op = 0;
  logic [11:0] addr = 0;
  logic [31:0] src = 0, pc = 0, insn = 0;
  logic [4:0]  zimm = 0;
  logic [31:0] rdata, rpc;
  logic        cill, rv;

  mtrap_csr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_op(op), .csr_addr(addr),
    .csr_src(src), .csr_zimm(zimm), .csr_src_x0(x0), .csr_rdata(rdata),
    .csr_illegal(cill), .exc_ecall(ecall), .exc_ebreak(ebreak),
    .exc_illegal(illeg), .trap_pc(pc), .trap_insn(insn), .irq_sw(isw),
    .irq_timer(itm), .irq_ext(iex), .flush_busy(fbusy), .mret_req(mret),
    .redirect_valid(rv), .redirect_pc(rpc));

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  logic [31:0] last_rdata;
  logic        last_rv, last_ill;
  logic [31:0] last_rpc;

  logic        m_mie = 0, m_mpie = 0;
  logic [31:0] m_ie = 0, m_tvec = 32'h100, m_scr = 0, m_epc = 0, m_cause = 0, m_tval = 0;

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, got, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [11:0] a, output logic ok);
    ok = 1'b1;
    case (a)
      12'h300: return 32'h1800 | (32'(m_mpie) << 7) | (32'(m_mie) << 3);
      12'h304: return m_ie;
      12'h305: return m_tvec;
      12'h340: return m_scr;
      12'h341: return m_epc;
      12'h342: return m_cause;
      12'h343: return m_tval;
      12'h344: return (32'(iex) << 11) | (32'(itm) << 7) | (32'(isw) << 3);
      default: begin ok = 1'b0; return 32'h0; end
    endcase
  endfunction

  task automatic cycle();
    logic ok, ill, exc, pe, ps, pt, tirq, tret, trap, wr, imm;
    logic [31:0] old, sv, nv, cause, erpc;
    #1;
    old  = mread(addr, ok);
    imm  = op[2];
    sv   = imm ? {27'b0, zimm} : src;
    ill  = req && (!ok || op[1:0] == 2'b00);
    exc  = ecall || ebreak || illeg;
    pe   = iex && m_ie[11];
    ps   = isw && m_ie[3];
    pt   = itm && m_ie[7];
    tirq = m_mie && (pe || ps || pt) && !fbusy && !exc && !mret;
    tret = mret && !exc;
    trap = exc || tirq;
    wr   = req && !ill && !trap && !tret &&
           (op[1:0] == 2'b01 || (imm ? zimm != 0 : !x0));
    nv   = (op[1:0] == 2'b01) ? sv : (op[1:0] == 2'b10) ? (old | sv) : (old & ~sv);
    cause = illeg ? 32'd2 : ebreak ? 32'd3 : ecall ? 32'd11 :
            pe ? 32'h8000000B : ps ? 32'h80000003 : 32'h80000007;
    erpc = trap ? m_tvec : m_epc;
    last_rdata = rdata; last_rv = rv; last_rpc = rpc; last_ill = cill;
    chk({cur_req, " illegal flag"}, 32'(cill), 32'(ill));
    chk({cur_req, " redirect"}, 32'(rv), 32'(trap || tret));
    if (trap || tret) chk({cur_req, " target"}, rpc, erpc);
    if (req && ok) chk({cur_req, " old value"}, rdata, old);
    @(posedge clk);
    if (trap) begin
      m_epc = pc & ~32'h3; m_cause = cause; m_tval = illeg ? insn : 32'h0;
      m_mpie = m_mie; m_mie = 1'b0;
    end else if (tret) begin
      m_mie = m_mpie; m_mpie = 1'b1;
    end else if (wr) begin
      case (addr)
        12'h300: begin m_mie = nv[3]; m_mpie = nv[7]; end
        12'h304: m_ie = nv & 32'h888;
        12'h305: m_tvec = nv & ~32'h3;
        12'h340: m_scr = nv;
        12'h341: m_epc = nv & ~32'h3;
        12'h342: m_cause = nv;
        12'h343: m_tval = nv;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic csr(input logic [2:0] o, input logic [11:0] a, input logic [31:0] s,
                     input logic [4:0] z, input logic zx);
    req = 1; op = o; addr = a; src = s; zimm = z; x0 = zx;
    cycle();
    req = 0; op = 0; x0 = 0; zimm = 0; src = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    csr(3'b010, a, 32'hDEAD_BEEF, 5'd0, 1'b1);
  endtask

  task automatic do_mret();
    mret = 1; cycle(); mret = 0;
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1"; rd(12'h340); chk("R1 reset scratch", last_rdata, 32'h0);
    cur_req = "R11"; rd(12'h300); chk("R11 reset status", last_rdata, 32'h1800);
    cur_req = "R7"; rd(12'h305); chk("R7 reset tvec", last_rdata, 32'h100);

    cur_req = "R1";
    csr(3'b001, 12'h340, 32'h0, 0, 0); chk("R1 write old", last_rdata, 32'h0);
    csr(3'b001, 12'h340, 32'h42, 0, 0); chk("R1 write 0x42 old", last_rdata, 32'h0);
    cur_req = "R3";
    csr(3'b010, 12'h340, 32'hFFFF_FFFF, 0, 1); chk("R3 set x0 read", last_rdata, 32'h42);
    rd(12'h340); chk("R3 no write", last_rdata, 32'h42);
    cur_req = "R2";
    csr(3'b010, 12'h340, 32'hF, 0, 0); chk("R2 set old", last_rdata, 32'h42);
    csr(3'b011, 12'h340, 32'hF, 0, 0); chk("R2 clear old", last_rdata, 32'h4F);
    cur_req = "R4";
    csr(3'b101, 12'h340, 32'hFFFF_0000, 5'h1F, 0); chk("R4 wi old", last_rdata, 32'h40);
    cur_req = "R3";
    csr(3'b110, 12'h340, 32'hFFFF_FFFF, 5'h0, 0); chk("R3 si zero", last_rdata, 32'h1F);
    csr(3'b111, 12'h340, 32'hFFFF_FFFF, 5'h0, 0);
    cur_req = "R4";
    csr(3'b111, 12'h340, 32'h0, 5'h10, 0); chk("R4 ci old", last_rdata, 32'h1F);
    rd(12'h340); chk("R4 after clear", last_rdata, 32'h0F);

    cur_req = "R11";
    csr(3'b001, 12'h341, 32'h1237, 0, 0); rd(12'h341); chk("R11 epc mask", last_rdata, 32'h1234);
    csr(3'b001, 12'h305, 32'h2003, 0, 0); rd(12'h305); chk("R11 tvec mask", last_rdata, 32'h2000);
    csr(3'b001, 12'h304, 32'hFFFF_FFFF, 0, 0); rd(12'h304); chk("R11 ie mask", last_rdata, 32'h888);
    csr(3'b001, 12'h300, 32'hFFFF_FFFF, 0, 0); rd(12'h300); chk("R11 status mask", last_rdata, 32'h1888);
    csr(3'b001, 12'h344, 32'hFFFF_FFFF, 0, 0); rd(12'h344); chk("R11 ip ignores write", last_rdata, 32'h0);

    cur_req = "R12";
    csr(3'b001, 12'h7C0, 32'h5, 0, 0); chk("R12 unimpl addr", 32'(last_ill), 32'h1);
    csr(3'b000, 12'h340, 32'h77, 0, 0); chk("R12 bad op", 32'(last_ill), 32'h1);
    csr(3'b100, 12'h340, 32'h77, 5'h3, 0);
    rd(12'h340); chk("R12 scratch kept", last_rdata, 32'h0F);

    cur_req = "R7";
    pc = 32'h80; ecall = 1; cycle(); ecall = 0;
    chk("R7 redirect", last_rpc, 32'h2000);
    rd(12'h300); chk("R7 status after entry", last_rdata, 32'h1880);
    cur_req = "R5"; rd(12'h342); chk("R5 ecall cause", last_rdata, 32'd11);
    cur_req = "R6"; rd(12'h341); chk("R6 epc", last_rdata, 32'h80);
    rd(12'h343); chk("R6 tval zero", last_rdata, 32'h0);
    cur_req = "R8";
    csr(3'b001, 12'h341, 32'h84, 0, 0);
    do_mret(); chk("R8 return target", last_rpc, 32'h84);
    rd(12'h300); chk("R8 status restored", last_rdata, 32'h1888);

    cur_req = "R5";
    pc = 32'h90; ebreak = 1; cycle(); ebreak = 0;
    rd(12'h342); chk("R5 ebreak cause", last_rdata, 32'd3);
    do_mret();
    pc = 32'hA0; insn = 32'hFFFF_FFFF; illeg = 1; ecall = 1; ebreak = 1; cycle();
    illeg = 0; ecall = 0; ebreak = 0;
    rd(12'h342); chk("R5 illegal wins", last_rdata, 32'd2);
    cur_req = "R6"; rd(12'h343); chk("R6 tval insn", last_rdata, 32'hFFFF_FFFF);
    do_mret();

    cur_req = "R9";
    pc = 32'hB0; itm = 1; cycle(); itm = 0;
    chk("R9 timer taken", 32'(last_rv), 32'h1);
    rd(12'h342); chk("R9 timer cause", last_rdata, 32'h8000_0007);
    do_mret();
    itm = 1; isw = 1; iex = 1; cycle(); itm = 0; isw = 0; iex = 0;
    rd(12'h342); chk("R9 ext first", last_rdata, 32'h8000_000B);
    do_mret();
    itm = 1; isw = 1; cycle(); itm = 0; isw = 0;
    rd(12'h342); chk("R9 sw over timer", last_rdata, 32'h8000_0003);
    do_mret();
    csr(3'b011, 12'h304, 32'h80, 0, 0);
    itm = 1; cycle(); chk("R9 masked by ie", 32'(last_rv), 32'h0);
    rd(12'h344); chk("R9 ip live", last_rdata, 32'h80);
    itm = 0;
    csr(3'b010, 12'h304, 32'h80, 0, 0);

    cur_req = "R10";
    itm = 1; fbusy = 1; cycle(); chk("R10 deferred in flush", 32'(last_rv), 32'h0);
    pc = 32'hC0; ecall = 1; cycle(); ecall = 0; fbusy = 0;
    chk("R10 exc in flush", 32'(last_rv), 32'h1);
    rd(12'h342); chk("R10 exc beats irq", last_rdata, 32'd11);
    itm = 0; do_mret();
    itm = 1; fbusy = 1; cycle(); fbusy = 0; cycle(); itm = 0;
    chk("R10 taken after flush", 32'(last_rv), 32'h1);
    do_mret();

    cur_req = "R13";
    req = 1; op = 3'b001; addr = 12'h340; src = 32'h99; ecall = 1; pc = 32'hD0;
    cycle(); req = 0; ecall = 0;
    rd(12'h340); chk("R13 no write on trap", last_rdata, 32'h0F);
    req = 1; op = 3'b001; addr = 12'h340; src = 32'h55; mret = 1;
    cycle(); req = 0; mret = 0;
    rd(12'h340); chk("R13 no write on return", last_rdata, 32'h0F);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule